// File: doc/BRIEF.md
# CAM Pointer Look-aside Table

This block sits beside a small fully-associative filter store and keeps a direct-mapped record of recent associative searches. Each record maps an address tag to the slot number in the filter's data array where that address lives. A lookup arrives together with the L1 result for the same access. If the L1 missed and the record at the address's index matches, the slot pointer comes back in the same cycle. The data array can then be read through it without starting the associative search.

When both the L1 and the table miss, the block runs the associative search over the filter's address store. The search takes a configurable number of cycles. A found slot is written into the table at the address's index. An address the filter does not hold is handed on to the next cache level. The filter's slot installs and evictions come in on two maintenance ports. These update the associative store and, in the same edge, clear every table record that points at the affected slot, so the table never returns a stale pointer. Two free-running counters report pointer hits and started searches.

Top module: `slot_ptr_cache`

## Requirements
- R1: After the clock edges with rst_n low, no table record is valid, busy, srch_done and fwd_req are low, and hit_cnt and srch_cnt are zero.
- R2: lk_hit is high in the same cycle exactly when lk_valid=1, l1_hit=0 and the record at the lookup index is valid with a matching tag. lk_slot then carries the stored slot; otherwise lk_slot is zero.
- R3: The index is lk_addr[IDX_W-1:0] and the tag is lk_addr[ADDR_W-1:IDX_W], with IDX_W=log2(ENTRIES). Each index keeps one record, and a newer fill replaces the older one.
- R4: A lookup with lk_valid=1, l1_hit=0 and a table miss while busy is low starts a search. busy is then high for exactly CAM_LAT cycles, beginning the cycle after the lookup, and srch_done is high only in the last of them. A missing lookup while busy is high starts nothing.
- R5: A lookup that hits in the table starts no search: busy stays low in the next cycle.
- R6: In the done cycle of a search that finds the address, srch_hit=1 and srch_slot is the lowest slot holding it. The table record at the address's index takes the tag and slot at the closing edge, so a later lookup returns the same slot as the search.
- R7: In the done cycle of a search that does not find the address, fwd_req=1, fwd_addr is the searched address, and the table is not written.
- R8: At an edge with slot_wr_en or slot_kill_en, every table record pointing at the named slot becomes invalid. The store slot takes slot_wr_addr on a write or becomes empty on a kill, and the write wins when both name the same slot.
- R9: If the done cycle of a successful search coincides with a write or kill of the found slot, the table fill is dropped. The search outputs still report the slot as it was in that cycle.
- R10: hit_cnt rises by one for each cycle with lk_hit high and srch_cnt by one for each started search, both wrapping modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Lookup line address |
| l1_hit | input | 1 | L1 result for the same access |
| lk_hit | output | 1 | Table pointer hit |
| lk_slot | output | SLOT_W | Filter slot on a pointer hit |
| busy | output | 1 | Associative search in progress |
| srch_done | output | 1 | Last cycle of a search |
| srch_hit | output | 1 | Search found the address |
| srch_slot | output | SLOT_W | Slot found by the search |
| fwd_req | output | 1 | Send the access to the next level |
| fwd_addr | output | ADDR_W | Address being searched or forwarded |
| slot_wr_en | input | 1 | Install an address into a filter slot |
| slot_wr_idx | input | SLOT_W | Slot being installed |
| slot_wr_addr | input | ADDR_W | Address being installed |
| slot_kill_en | input | 1 | Evict a filter slot |
| slot_kill_idx | input | SLOT_W | Slot being evicted |
| hit_cnt | output | CNT_W | Pointer hit count |
| srch_cnt | output | CNT_W | Started search count |

## Verification
The table fill at the end of a search and the invalidation caused by a slot eviction can land on the same edge. The bench provokes this by asserting slot_kill_en in the done cycle of a search. In one run the kill names the slot just found, and the fill must be dropped: the next lookup of that address misses the table and then misses the store. In the other run the kill names a different slot, and the fill must survive as a pointer hit. A lookup in the first busy cycle of each search checks that a second miss is ignored, judged by the search count.

// File: rtl/spc_pkg.sv
// Package: shared state type and sizing helper for the slot pointer table.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package spc_pkg;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_t;

    // Width needed to index v items, never below one bit.
    function automatic int clog2_min1(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/spc_table.sv
// Module: spc_table
// Direct-mapped pointer records: tag plus filter slot per index.
// Read is combinational. A fill writes one record; two invalidate
// ports clear every record pointing at a given slot. Assumes that the
// caller never fills a slot that is being invalidated in the same cycle.
module spc_table #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3,
    parameter int TAG_W   = 13,
    parameter int SLOT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [SLOT_W-1:0] rd_slot,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic              inv_a_en,
    input  logic [SLOT_W-1:0] inv_a_slot,
    input  logic              inv_b_en,
    input  logic [SLOT_W-1:0] inv_b_slot
);

    logic [ENTRIES-1:0] ent_vld;
    logic [TAG_W-1:0]   ent_tag  [ENTRIES];
    logic [SLOT_W-1:0]  ent_slot [ENTRIES];
    logic [ENTRIES-1:0] ent_kill;

    // Per-record flag: this record points at a slot being invalidated.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_kill
        assign ent_kill[e] = ent_vld[e] &&
            ((inv_a_en && (ent_slot[e] == inv_a_slot)) ||
             (inv_b_en && (ent_slot[e] == inv_b_slot)));
    end

    // Combinational lookup of the indexed record.
    always_comb begin
        rd_hit  = ent_vld[rd_idx] && (ent_tag[rd_idx] == rd_tag);
        rd_slot = ent_slot[rd_idx];
    end

    // Record update: fill wins on its own index, invalidate clears others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (fill_en && (fill_idx == IDX_W'(e))) begin
                    ent_vld[e]  <= 1'b1;
                    ent_tag[e]  <= fill_tag;
                    ent_slot[e] <= fill_slot;
                end else if (ent_kill[e]) begin
                    ent_vld[e] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/spc_cam.sv
// Module: spc_cam
// Fully-associative address store of the filter, one address per slot.
// Match is combinational over all slots; the lowest matching slot wins.
// A write installs an address and a kill empties a slot; on the same
// slot in the same cycle the write takes effect.
module spc_cam #(
    parameter int NSLOTS = 32,
    parameter int ADDR_W = 16,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              kill_en,
    input  logic [SLOT_W-1:0] kill_idx,
    input  logic [ADDR_W-1:0] key,
    output logic              match_hit,
    output logic [SLOT_W-1:0] match_slot
);

    logic [NSLOTS-1:0] slot_vld;
    logic [ADDR_W-1:0] slot_addr [NSLOTS];
    logic [NSLOTS-1:0] match_vec;

    // Parallel compare of the key against every occupied slot.
    for (genvar s = 0; s < NSLOTS; s++) begin : g_cmp
        assign match_vec[s] = slot_vld[s] && (slot_addr[s] == key);
    end

    // Priority encode: lowest matching slot.
    always_comb begin
        match_hit  = |match_vec;
        match_slot = '0;
        for (int s = NSLOTS - 1; s >= 0; s--) begin
            if (match_vec[s]) match_slot = SLOT_W'(s);
        end
    end

    // Slot install and eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
        end else begin
            for (int s = 0; s < NSLOTS; s++) begin
                if (kill_en && (kill_idx == SLOT_W'(s))) slot_vld[s] <= 1'b0;
                if (wr_en && (wr_idx == SLOT_W'(s))) begin
                    slot_vld[s]  <= 1'b1;
                    slot_addr[s] <= wr_addr;
                end
            end
        end
    end

endmodule

// File: rtl/spc_seq.sv
// Module: spc_seq
// Search sequencer: starts an associative search on a double miss,
// holds the address for CAM_LAT cycles, then fills the table or
// forwards the access. Also keeps the hit and search counters.
// Assumes CAM_LAT >= 1.
module spc_seq
    import spc_pkg::*;
#(
    parameter int CAM_LAT = 3,
    parameter int ADDR_W  = 16,
    parameter int SLOT_W  = 5,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              l1_hit,
    input  logic              tbl_hit,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              cam_hit,
    input  logic [SLOT_W-1:0] cam_slot,
    input  logic              inv_a_en,
    input  logic [SLOT_W-1:0] inv_a_slot,
    input  logic              inv_b_en,
    input  logic [SLOT_W-1:0] inv_b_slot,
    output logic              busy,
    output logic              done,
    output logic              fill_en,
    output logic              fwd_req,
    output logic              ptr_hit,
    output logic [ADDR_W-1:0] key_addr,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  srch_cnt
);

    localparam int LAT_W = clog2_min1(CAM_LAT);

    seq_state_t       state;
    logic [LAT_W-1:0] lat_cnt;
    logic             start;
    logic             clash;

    // Request decode for the current lookup.
    always_comb begin
        ptr_hit = lk_valid && !l1_hit && tbl_hit;
        start   = lk_valid && !l1_hit && !tbl_hit && (state == SQ_IDLE);
    end

    // Search completion and the fill/forward decision.
    always_comb begin
        busy    = (state == SQ_RUN);
        done    = busy && (lat_cnt == '0);
        clash   = (inv_a_en && (inv_a_slot == cam_slot)) ||
                  (inv_b_en && (inv_b_slot == cam_slot));
        fill_en = done && cam_hit && !clash;
        fwd_req = done && !cam_hit;
    end

    // Search state, latency count and held address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            lat_cnt  <= '0;
            key_addr <= '0;
        end else if (state == SQ_IDLE) begin
            if (start) begin
                state    <= SQ_RUN;
                lat_cnt  <= LAT_W'(CAM_LAT - 1);
                key_addr <= lk_addr;
            end
        end else if (lat_cnt == '0) begin
            state <= SQ_IDLE;
        end else begin
            lat_cnt <= lat_cnt - 1'b1;
        end
    end

    // Wrapping event counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt  <= '0;
            srch_cnt <= '0;
        end else begin
            if (ptr_hit) hit_cnt  <= hit_cnt + 1'b1;
            if (start)   srch_cnt <= srch_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/slot_ptr_cache.sv
// Module: slot_ptr_cache
// Top: direct-mapped pointer table in front of the filter's associative
// address store. Same-cycle pointer lookup, multi-cycle search on a
// double miss, table fill or next-level forward at the end, and slot
// maintenance that invalidates stale pointers. Assumes ENTRIES is a
// power of two and that the filter never holds one address twice.
module slot_ptr_cache #(
    parameter  int ADDR_W  = 16,
    parameter  int ENTRIES = 8,
    parameter  int NSLOTS  = 32,
    parameter  int CAM_LAT = 3,
    parameter  int CNT_W   = 16,
    localparam int IDX_W   = spc_pkg::clog2_min1(ENTRIES),
    localparam int TAG_W   = ADDR_W - IDX_W,
    localparam int SLOT_W  = spc_pkg::clog2_min1(NSLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              l1_hit,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    output logic              busy,
    output logic              srch_done,
    output logic              srch_hit,
    output logic [SLOT_W-1:0] srch_slot,
    output logic              fwd_req,
    output logic [ADDR_W-1:0] fwd_addr,
    input  logic              slot_wr_en,
    input  logic [SLOT_W-1:0] slot_wr_idx,
    input  logic [ADDR_W-1:0] slot_wr_addr,
    input  logic              slot_kill_en,
    input  logic [SLOT_W-1:0] slot_kill_idx,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  srch_cnt
);

    logic              tbl_hit;
    logic [SLOT_W-1:0] tbl_slot;
    logic              cam_hit;
    logic [SLOT_W-1:0] cam_slot;
    logic              fill_en;
    logic              ptr_hit;
    logic              done;
    logic [ADDR_W-1:0] key_addr;

    spc_table #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .SLOT_W(SLOT_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_addr[IDX_W-1:0]),
        .rd_tag    (lk_addr[ADDR_W-1:IDX_W]),
        .rd_hit    (tbl_hit),
        .rd_slot   (tbl_slot),
        .fill_en   (fill_en),
        .fill_idx  (key_addr[IDX_W-1:0]),
        .fill_tag  (key_addr[ADDR_W-1:IDX_W]),
        .fill_slot (cam_slot),
        .inv_a_en  (slot_wr_en),
        .inv_a_slot(slot_wr_idx),
        .inv_b_en  (slot_kill_en),
        .inv_b_slot(slot_kill_idx)
    );

    spc_cam #(
        .NSLOTS(NSLOTS), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
    ) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (slot_wr_en),
        .wr_idx    (slot_wr_idx),
        .wr_addr   (slot_wr_addr),
        .kill_en   (slot_kill_en),
        .kill_idx  (slot_kill_idx),
        .key       (key_addr),
        .match_hit (cam_hit),
        .match_slot(cam_slot)
    );

    spc_seq #(
        .CAM_LAT(CAM_LAT), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .l1_hit    (l1_hit),
        .tbl_hit   (tbl_hit),
        .lk_addr   (lk_addr),
        .cam_hit   (cam_hit),
        .cam_slot  (cam_slot),
        .inv_a_en  (slot_wr_en),
        .inv_a_slot(slot_wr_idx),
        .inv_b_en  (slot_kill_en),
        .inv_b_slot(slot_kill_idx),
        .busy      (busy),
        .done      (done),
        .fill_en   (fill_en),
        .fwd_req   (fwd_req),
        .ptr_hit   (ptr_hit),
        .key_addr  (key_addr),
        .hit_cnt   (hit_cnt),
        .srch_cnt  (srch_cnt)
    );

    // Output shaping: pointer and search results are zero when unused.
    always_comb begin
        lk_hit    = ptr_hit;
        lk_slot   = ptr_hit ? tbl_slot : '0;
        srch_done = done;
        srch_hit  = done && cam_hit;
        srch_slot = (done && cam_hit) ? cam_slot : '0;
        fwd_addr  = key_addr;
    end

endmodule

// File: rtl/spc_chk.sv
// Module: spc_chk
// Property checker for slot_ptr_cache, attached by bind below.
// Observes ports only; keeps one cycle counter for the search window.
module spc_chk #(
    parameter int CAM_LAT = 3,
    parameter int SLOT_W  = 5,
    parameter int CNT_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              l1_hit,
    input logic              lk_hit,
    input logic [SLOT_W-1:0] lk_slot,
    input logic              busy,
    input logic              srch_done,
    input logic              srch_hit,
    input logic              fwd_req,
    input logic              slot_wr_en,
    input logic [SLOT_W-1:0] slot_wr_idx,
    input logic              slot_kill_en,
    input logic [SLOT_W-1:0] slot_kill_idx,
    input logic [CNT_W-1:0]  hit_cnt,
    input logic [CNT_W-1:0]  srch_cnt
);

    logic [15:0] run_cnt;

    // Cycles spent busy in the current search.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_cnt <= '0;
        else                 run_cnt <= run_cnt + 1'b1;
    end

    a_r2_no_hit_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid || l1_hit) |-> !lk_hit);

    a_r4_miss_starts_search: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !l1_hit && !lk_hit && !busy) |=> busy);

    a_r4_done_at_latency: assert property (@(posedge clk) disable iff (!rst_n)
        srch_done |-> (busy && (run_cnt == 16'(CAM_LAT - 1))));

    a_r4_done_ends_search: assert property (@(posedge clk) disable iff (!rst_n)
        srch_done |=> !busy);

    a_r5_hit_no_search: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !busy) |=> !busy);

    a_r7_forward_on_miss_only: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req |-> (srch_done && !srch_hit));

    a_r8_kill_clears_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        slot_kill_en |=> !(lk_hit && (lk_slot == $past(slot_kill_idx))));

    a_r8_write_clears_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        slot_wr_en |=> !(lk_hit && (lk_slot == $past(slot_wr_idx))));

    a_r10_hit_count: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> (hit_cnt == $past(hit_cnt) + 1'b1));

    a_r10_search_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (srch_cnt == $past(srch_cnt) + 1'b1));

endmodule

bind slot_ptr_cache spc_chk #(
    .CAM_LAT(CAM_LAT), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .l1_hit       (l1_hit),
    .lk_hit       (lk_hit),
    .lk_slot      (lk_slot),
    .busy         (busy),
    .srch_done    (srch_done),
    .srch_hit     (srch_hit),
    .fwd_req      (fwd_req),
    .slot_wr_en   (slot_wr_en),
    .slot_wr_idx  (slot_wr_idx),
    .slot_kill_en (slot_kill_en),
    .slot_kill_idx(slot_kill_idx),
    .hit_cnt      (hit_cnt),
    .srch_cnt     (srch_cnt)
);

// File: tb/slot_ptr_cache_bench.sv
// Bench: small configuration, address sweeps against a reference model
// of the table and the slot store kept from the requirements.
module slot_ptr_cache_bench;

    localparam int AW  = 8;
    localparam int EN  = 8;
    localparam int NS  = 8;
    localparam int LAT = 3;
    localparam int CW  = 16;
    localparam int SW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          l1_hit = 1'b0;
    logic          lk_hit;
    logic [SW-1:0] lk_slot;
    logic          busy;
    logic          srch_done;
    logic          srch_hit;
    logic [SW-1:0] srch_slot;
    logic          fwd_req;
    logic [AW-1:0] fwd_addr;
    logic          slot_wr_en = 1'b0;
    logic [SW-1:0] slot_wr_idx = '0;
    logic [AW-1:0] slot_wr_addr = '0;
    logic          slot_kill_en = 1'b0;
    logic [SW-1:0] slot_kill_idx = '0;
    logic [CW-1:0] hit_cnt;
    logic [CW-1:0] srch_cnt;

    always #2.5 clk = ~clk;

    slot_ptr_cache #(
        .ADDR_W(AW), .ENTRIES(EN), .NSLOTS(NS), .CAM_LAT(LAT), .CNT_W(CW)
    ) u_slot_ptr_cache (.*);

    int checks = 0;
    int errors = 0;
    int exp_hits = 0;
    int exp_srch = 0;
    int  m_cam_addr [NS];
    bit  m_cam_v    [NS];
    bit  m_tv [EN];
    int  m_tt [EN];
    int  m_ts [EN];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic idle_inputs();
        lk_valid = 1'b0; l1_hit = 1'b0;
        slot_wr_en = 1'b0; slot_kill_en = 1'b0;
    endtask

    task automatic cam_find(input int addr, output bit found, output int slot);
        found = 1'b0; slot = 0;
        for (int s = NS - 1; s >= 0; s--)
            if (m_cam_v[s] && m_cam_addr[s] == addr) begin found = 1'b1; slot = s; end
    endtask

    task automatic model_inv(input int slot);
        for (int e = 0; e < EN; e++) if (m_tv[e] && m_ts[e] == slot) m_tv[e] = 1'b0;
    endtask

    task automatic install(input int slot, input int addr);
        @(negedge clk); idle_inputs();
        slot_wr_en = 1'b1; slot_wr_idx = SW'(slot); slot_wr_addr = AW'(addr);
        @(posedge clk);
        model_inv(slot);
        m_cam_v[slot] = 1'b1; m_cam_addr[slot] = addr;
    endtask

    task automatic kill(input int slot);
        @(negedge clk); idle_inputs();
        slot_kill_en = 1'b1; slot_kill_idx = SW'(slot);
        @(posedge clk);
        model_inv(slot);
        m_cam_v[slot] = 1'b0;
    endtask

    // One lookup; on a double miss follows the search to its end.
    // kill_slot >= 0 evicts that slot in the search's done cycle.
    task automatic do_lookup(input int addr, input bit l1, input int kill_slot, input string tg);
        int idx; int tag; bit exp_hit; bit f; int s;
        idx = addr % EN; tag = addr / EN;
        @(negedge clk); idle_inputs();
        lk_valid = 1'b1; lk_addr = AW'(addr); l1_hit = l1;
        #1;
        exp_hit = !l1 && m_tv[idx] && (m_tt[idx] == tag);
        chk(lk_hit == exp_hit, {tg, " R2/R3 hit"}, lk_hit, exp_hit);
        if (exp_hit) begin
            chk(int'(lk_slot) == m_ts[idx], {tg, " R6 slot"}, lk_slot, m_ts[idx]);
            cam_find(addr, f, s);
            chk(f && int'(lk_slot) == s, {tg, " R6 equals search"}, lk_slot, s);
            exp_hits++;
        end else begin
            chk(lk_slot == '0, {tg, " R2 slot zero"}, lk_slot, 0);
        end
        @(posedge clk);
        if (!l1 && !exp_hit) begin
            exp_srch++;
            for (int k = 1; k <= LAT; k++) begin
                @(negedge clk); idle_inputs();
                if (k == 1) begin lk_valid = 1'b1; lk_addr = AW'(addr); end
                if (k == LAT && kill_slot >= 0) begin
                    slot_kill_en = 1'b1; slot_kill_idx = SW'(kill_slot);
                end
                #1;
                if (k == 1) chk(lk_hit == 1'b0, "R4 busy lookup", lk_hit, 0);
                chk(busy == 1'b1, "R4 busy", busy, 1);
                chk(srch_done == (k == LAT), "R4 done timing", srch_done, k == LAT);
                if (k == LAT) begin
                    cam_find(addr, f, s);
                    chk(srch_hit == f, {tg, " R6/R7 search hit"}, srch_hit, f);
                    if (f) chk(int'(srch_slot) == s, {tg, " R6 search slot"}, srch_slot, s);
                    chk(fwd_req == !f, {tg, " R7 forward"}, fwd_req, !f);
                    if (!f) chk(int'(fwd_addr) == addr, "R7 forward addr", fwd_addr, addr);
                end
                @(posedge clk);
                if (k == LAT) begin
                    if (kill_slot >= 0) begin model_inv(kill_slot); m_cam_v[kill_slot] = 1'b0; end
                    if (f && kill_slot != s) begin
                        m_tv[idx] = 1'b1; m_tt[idx] = tag; m_ts[idx] = s;
                    end
                end
            end
            @(negedge clk); idle_inputs(); #1;
            chk(busy == 1'b0, "R4 search ends", busy, 0);
        end else begin
            @(negedge clk); idle_inputs(); #1;
            chk(busy == 1'b0, "R5 no search", busy, 0);
        end
    endtask

    task automatic check_counts();
        @(negedge clk); idle_inputs(); #1;
        chk(int'(hit_cnt) == exp_hits, "R10 hit count", hit_cnt, exp_hits);
        chk(int'(srch_cnt) == exp_srch, "R10 search count", srch_cnt, exp_srch);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int inst_addr [NS];
        inst_addr = '{8'h03, 8'h13, 8'h2B, 8'h40, 8'h51, 8'h66, 8'h7F, 8'h8E};
        for (int e = 0; e < EN; e++) m_tv[e] = 1'b0;
        for (int s = 0; s < NS; s++) m_cam_v[s] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(srch_done == 1'b0 && fwd_req == 1'b0, "R1 done/forward", fwd_req, 0);
        chk(hit_cnt == '0 && srch_cnt == '0, "R1 counters", hit_cnt, 0);
        do_lookup(8'h03, 1'b0, -1, "R1 empty table");

        for (int s = 0; s < NS; s++) install(s, inst_addr[s]);
        for (int a = 0; a < 256; a++) do_lookup(a, 1'b0, -1, "sweep1");
        for (int a = 0; a < 256; a++) do_lookup(a, (a % 5) == 0, -1, "sweep2");
        check_counts();

        // R3: same index, newer fill replaces older one.
        do_lookup(8'h03, 1'b0, -1, "R3 a");
        do_lookup(8'h13, 1'b0, -1, "R3 b");
        do_lookup(8'h03, 1'b0, -1, "R3 c");

        // R8: kill and re-install invalidate pointers.
        do_lookup(8'h13, 1'b0, -1, "R8 fill");
        kill(1);
        do_lookup(8'h13, 1'b0, -1, "R8 after kill");
        do_lookup(8'h2B, 1'b0, -1, "R8 fill");
        install(2, 8'hC3);
        do_lookup(8'h2B, 1'b0, -1, "R8 after write");
        do_lookup(8'hC3, 1'b0, -1, "R8 new");
        do_lookup(8'hC3, 1'b0, -1, "R8 new hit");

        // R9: fill and eviction in the same cycle.
        install(1, 8'h99);
        do_lookup(8'h99, 1'b0, 1, "R9 clash");
        do_lookup(8'h99, 1'b0, -1, "R9 after clash");
        install(1, 8'h99);
        do_lookup(8'h99, 1'b0, 5, "R9 other slot");
        do_lookup(8'h99, 1'b0, -1, "R9 kept");
        check_counts();

        for (int a = 0; a < 256; a++) do_lookup(a, 1'b0, -1, "sweep3");
        check_counts();
        finish_up();
    end

endmodule